// File: doc/BRIEF.md
# Interrupt Entry and Return Unit

This block owns the program counter and status register of a processor core and applies the two context switches that interrupts cause. When an interrupt is taken it saves the current program counter, status register and stack general register into three saved-context registers. In the same clock edge it records the event code, raises the block, privileged-mode and register-bank flags, and sends execution to a fixed handler address 0x600 above the vector base. A return-from-exception strobe brings back the program counter and status register from the saved copies. The stack register is not touched by a return: its next value always follows the core's own value.

In cycles with no context switch the program counter takes the core's sequential next address. The status register takes a core write when one is requested. Priority arbitration between interrupt sources, instruction decode and register bank storage sit outside the block. The block only sees one request with its level and code.

Each cycle is one of four actions, chosen in priority order. ACT_RETURN is taken when the return strobe is high. ACT_ENTER is taken for a reset-type entry, or for an interrupt request that passes qualification. ACT_SRWR is a core write of the status register. ACT_IDLE is plain sequential flow. The transitions are: any action to ACT_RETURN on the return strobe; to ACT_ENTER on reset entry or a qualified request; to ACT_SRWR on a status write; otherwise ACT_IDLE.

Top module: `ictx_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` becomes 0xA0000000 and `sr_q` becomes 0x700000F0: mode bit 30, bank bit 29 and block bit 28 set, mask bits 7:4 = 0xF, every other bit 0. `spc_q`, `ssr_q`, `sgr_q` and `intevt_q` become 0.
- R2: On an entry, `spc_q`, `ssr_q` and `sgr_q` take the pre-entry `pc_q`, the pre-entry `sr_q` and `gr15_in`, all at the same edge.
- R3: On an entry, SR bits 30 (mode), 29 (bank) and 28 (block) become 1.
- R4: On an entry with `rst_entry`=1, SR bit 15 (FPU disable) becomes 0. On an interrupt entry, bit 15 keeps its previous value.
- R5: On an entry, `intevt_q[13:0]` takes `evt_code` and `intevt_q[31:14]` is 0.
- R6: On an entry, `pc_q` becomes `vbr_in` + 0x600, modulo 2^32.
- R7: On an entry with `mask_upd_en`=1, SR bits 7:4 take `acc_lvl`. With `mask_upd_en`=0 they keep their previous value.
- R8: `acc_req` is taken only when SR bit 28 is 0 and `acc_lvl` is greater than SR bits 7:4, compared unsigned. A request that is refused changes no saved register and no event register, and the cycle behaves as if no request came.
- R9: A return (`rte_req`=1) loads `pc_q` from `spc_q` and `sr_q` from `ssr_q`. It leaves the saved registers and the event register unchanged. `gr15_nxt` always equals `gr15_in` and never `sgr_q`.
- R10: When `rte_req` is high in the same cycle as an entry condition, the return is taken and the entry is dropped.
- R11: In a cycle with no return and no entry, `pc_q` takes `pc_seq`. `sr_q` takes `sr_wr_data` if `sr_wr_en`=1 and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_seq | input | 32 | Sequential next program counter from the core |
| sr_wr_en | input | 1 | Core writes the status register this cycle |
| sr_wr_data | input | 32 | Status register value written by the core |
| gr15_in | input | 32 | Current stack general register |
| vbr_in | input | 32 | Vector base |
| acc_req | input | 1 | Interrupt request from the arbiter |
| acc_lvl | input | 4 | Priority level of the request |
| evt_code | input | 14 | Event code of the request |
| rst_entry | input | 1 | Reset-type entry, taken without qualification |
| mask_upd_en | input | 1 | Load the SR mask with the accepted level |
| rte_req | input | 1 | Return-from-exception strobe |
| pc_q | output | 32 | Program counter |
| sr_q | output | 32 | Status register |
| gr15_nxt | output | 32 | Next stack general register value |
| spc_q | output | 32 | Saved program counter |
| ssr_q | output | 32 | Saved status register |
| sgr_q | output | 32 | Saved stack general register |
| intevt_q | output | 32 | Interrupt event register |

## Verification
The bench aims at the qualification edge. A request whose level equals the mask must be refused; a design using `>=` would enter and overwrite the saved context. Requests made while the block bit is set must also be refused; a design that ignores the block bit would nest handlers and lose the first saved PC. The bench also drives a return and an entry in the same cycle, where wrong priority shows up as a jump to the vector address. It checks that the FPU-disable bit is cleared only by a reset-type entry, that the mask is loaded only under `mask_upd_en`, and that the stack register is not restored on return. A vector base near the top of the address space checks that the handler address wraps at 32 bits.

// File: rtl/ictx_pkg.sv
package ictx_pkg;
    localparam int XLEN      = 32;
    localparam int LVL_W     = 4;
    localparam int CODE_W    = 14;
    localparam int SR_MD     = 30;
    localparam int SR_RB     = 29;
    localparam int SR_BL     = 28;
    localparam int SR_FD     = 15;
    localparam int SR_IM_LO  = 4;
    localparam logic [XLEN-1:0] VEC_OFS = 32'h0000_0600;
    localparam logic [XLEN-1:0] RST_PC  = 32'hA000_0000;
    localparam logic [LVL_W-1:0] RST_IMASK = '1;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_SRWR   = 2'd1,
        ACT_ENTER  = 2'd2,
        ACT_RETURN = 2'd3
    } ctx_act_e;
endpackage

// File: rtl/ictx_decode.sv
module ictx_decode
    import ictx_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rte_req,
    input  logic          rst_entry,
    input  logic          acc_req,
    input  logic [LW-1:0] acc_lvl,
    input  logic          sr_wr_en,
    input  logic          sr_bl,
    input  logic [LW-1:0] sr_imask,
    output ctx_act_e      act
);
    logic irq_ok;

    always_comb begin
        irq_ok = acc_req && !sr_bl && (acc_lvl > sr_imask);
        if (rte_req)
            act = ACT_RETURN;
        else if (rst_entry || irq_ok)
            act = ACT_ENTER;
        else if (sr_wr_en)
            act = ACT_SRWR;
        else
            act = ACT_IDLE;
    end

    // R10: a return strobe always wins over an entry
    p_rte_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && (rst_entry || acc_req)) |-> (act == ACT_RETURN));

    // R8: an interrupt entry only under an open block bit and higher level
    p_qualify_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ENTER && !rst_entry) |-> (!sr_bl && acc_lvl > sr_imask));
endmodule

// File: rtl/ictx_srgen.sv
module ictx_srgen
    import ictx_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int LW = LVL_W
) (
    input  logic [XW-1:0] sr_cur,
    input  logic          rst_entry,
    input  logic          mask_upd_en,
    input  logic [LW-1:0] acc_lvl,
    output logic [XW-1:0] sr_ent
);
    always_comb begin
        sr_ent        = sr_cur;
        sr_ent[SR_MD] = 1'b1;
        sr_ent[SR_RB] = 1'b1;
        sr_ent[SR_BL] = 1'b1;
        if (rst_entry)
            sr_ent[SR_FD] = 1'b0;
        if (mask_upd_en)
            sr_ent[SR_IM_LO +: LW] = acc_lvl;
    end
endmodule

// File: rtl/ictx_regs.sv
module ictx_regs
    import ictx_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = CODE_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctx_act_e      act,
    input  logic [XW-1:0] pc_seq,
    input  logic [XW-1:0] sr_wr_data,
    input  logic [XW-1:0] sr_ent,
    input  logic [XW-1:0] vbr_in,
    input  logic [XW-1:0] gr15_in,
    input  logic [CW-1:0] evt_code,
    output logic [XW-1:0] pc_q,
    output logic [XW-1:0] sr_q,
    output logic [XW-1:0] spc_q,
    output logic [XW-1:0] ssr_q,
    output logic [XW-1:0] sgr_q,
    output logic [XW-1:0] evt_q
);
    localparam logic [XW-1:0] RST_SR =
        (XW'(1) << SR_MD) | (XW'(1) << SR_RB) | (XW'(1) << SR_BL) |
        (XW'(RST_IMASK) << SR_IM_LO);

    logic [XW-1:0] pc_d, sr_d, spc_d, ssr_d, sgr_d, evt_d;

    always_comb begin
        pc_d  = pc_q;
        sr_d  = sr_q;
        spc_d = spc_q;
        ssr_d = ssr_q;
        sgr_d = sgr_q;
        evt_d = evt_q;
        unique case (act)
            ACT_IDLE: begin
                pc_d = pc_seq;
            end
            ACT_SRWR: begin
                pc_d = pc_seq;
                sr_d = sr_wr_data;
            end
            ACT_ENTER: begin
                spc_d = pc_q;
                ssr_d = sr_q;
                sgr_d = gr15_in;
                evt_d = XW'(evt_code);
                pc_d  = vbr_in + VEC_OFS;
                sr_d  = sr_ent;
            end
            ACT_RETURN: begin
                pc_d = spc_q;
                sr_d = ssr_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= RST_PC;
            sr_q  <= RST_SR;
            spc_q <= '0;
            ssr_q <= '0;
            sgr_q <= '0;
            evt_q <= '0;
        end else begin
            pc_q  <= pc_d;
            sr_q  <= sr_d;
            spc_q <= spc_d;
            ssr_q <= ssr_d;
            sgr_q <= sgr_d;
            evt_q <= evt_d;
        end
    end

    // R2: the three saved copies are taken from the pre-entry state
    p_save_ctx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ENTER) |=> (spc_q == $past(pc_q) && ssr_q == $past(sr_q)
                                && sgr_q == $past(gr15_in)));

    // R3: entry raises mode, bank and block flags
    p_entry_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ENTER) |=> (sr_q[SR_MD] && sr_q[SR_RB] && sr_q[SR_BL]));

    // R6: handler address sits at a fixed offset from the vector base
    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ENTER) |=> (pc_q == $past(vbr_in) + VEC_OFS));

    // R9: return restores PC and SR from the saved copies
    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RETURN) |=> (pc_q == $past(spc_q) && sr_q == $past(ssr_q)));

    // R8: saved context and event register move only on an entry
    p_saved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act != ACT_ENTER) |=> ($stable(spc_q) && $stable(ssr_q)
                                && $stable(sgr_q) && $stable(evt_q)));

    // R5: bits above the event code field stay clear
    p_evt_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ENTER) |=> (evt_q[XW-1:CW] == '0));
endmodule

// File: rtl/ictx_unit.sv
module ictx_unit
    import ictx_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int LW = LVL_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pc_seq,
    input  logic          sr_wr_en,
    input  logic [XW-1:0] sr_wr_data,
    input  logic [XW-1:0] gr15_in,
    input  logic [XW-1:0] vbr_in,
    input  logic          acc_req,
    input  logic [LW-1:0] acc_lvl,
    input  logic [CW-1:0] evt_code,
    input  logic          rst_entry,
    input  logic          mask_upd_en,
    input  logic          rte_req,
    output logic [XW-1:0] pc_q,
    output logic [XW-1:0] sr_q,
    output logic [XW-1:0] gr15_nxt,
    output logic [XW-1:0] spc_q,
    output logic [XW-1:0] ssr_q,
    output logic [XW-1:0] sgr_q,
    output logic [XW-1:0] intevt_q
);
    ctx_act_e      act;
    logic [XW-1:0] sr_ent;

    ictx_decode #(.LW(LW)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .rte_req   (rte_req),
        .rst_entry (rst_entry),
        .acc_req   (acc_req),
        .acc_lvl   (acc_lvl),
        .sr_wr_en  (sr_wr_en),
        .sr_bl     (sr_q[SR_BL]),
        .sr_imask  (sr_q[SR_IM_LO +: LW]),
        .act       (act)
    );

    ictx_srgen #(.XW(XW), .LW(LW)) u_srgen (
        .sr_cur      (sr_q),
        .rst_entry   (rst_entry),
        .mask_upd_en (mask_upd_en),
        .acc_lvl     (acc_lvl),
        .sr_ent      (sr_ent)
    );

    ictx_regs #(.XW(XW), .CW(CW), .LW(LW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .pc_seq     (pc_seq),
        .sr_wr_data (sr_wr_data),
        .sr_ent     (sr_ent),
        .vbr_in     (vbr_in),
        .gr15_in    (gr15_in),
        .evt_code   (evt_code),
        .pc_q       (pc_q),
        .sr_q       (sr_q),
        .spc_q      (spc_q),
        .ssr_q      (ssr_q),
        .sgr_q      (sgr_q),
        .evt_q      (intevt_q)
    );

    // R9: the stack register is never reloaded from the saved copy
    assign gr15_nxt = gr15_in;
endmodule

// File: tb/ictx_unit_bench.sv
module ictx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_seq = '0, sr_wr_data = '0, gr15_in = '0, vbr_in = '0;
    logic        sr_wr_en = 0, acc_req = 0, rst_entry = 0, mask_upd_en = 0, rte_req = 0;
    logic [3:0]  acc_lvl = '0;
    logic [13:0] evt_code = '0;
    logic [31:0] pc_q, sr_q, gr15_nxt, spc_q, ssr_q, sgr_q, intevt_q;

    int n_run = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [31:0] m_pc, m_sr, m_spc, m_ssr, m_sgr, m_evt;

    always #10 clk = ~clk;

    ictx_unit u_ictx_unit (
        .clk(clk), .rst_n(rst_n), .pc_seq(pc_seq), .sr_wr_en(sr_wr_en),
        .sr_wr_data(sr_wr_data), .gr15_in(gr15_in), .vbr_in(vbr_in),
        .acc_req(acc_req), .acc_lvl(acc_lvl), .evt_code(evt_code),
        .rst_entry(rst_entry), .mask_upd_en(mask_upd_en), .rte_req(rte_req),
        .pc_q(pc_q), .sr_q(sr_q), .gr15_nxt(gr15_nxt), .spc_q(spc_q),
        .ssr_q(ssr_q), .sgr_q(sgr_q), .intevt_q(intevt_q)
    );

    always @(posedge clk) begin
        logic [31:0] s;
        int cur_mask;
        if (!rst_n) begin
            m_pc = 32'hA000_0000; m_sr = 32'h7000_00F0;
            m_spc = 0; m_ssr = 0; m_sgr = 0; m_evt = 0;
        end else begin
            cur_mask = int'((m_sr >> 4) & 32'hF);
            if (rte_req) begin
                m_pc = m_spc; m_sr = m_ssr;
            end else if (rst_entry ||
                         (acc_req && m_sr[28] == 1'b0 && int'(acc_lvl) > cur_mask)) begin
                m_spc = m_pc; m_ssr = m_sr; m_sgr = gr15_in;
                m_evt = {18'd0, evt_code};
                s = m_sr | 32'h7000_0000;
                if (rst_entry) s = s & ~32'h0000_8000;
                if (mask_upd_en) s = (s & ~32'h0000_00F0) | ({28'd0, acc_lvl} << 4);
                m_sr = s;
                m_pc = vbr_in + 32'h600;
            end else begin
                m_pc = pc_seq;
                if (sr_wr_en) m_sr = sr_wr_data;
            end
        end
    end

    task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, nm, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "pc", pc_q, m_pc);
        cmp(tag, "sr", sr_q, m_sr);
        cmp(tag, "spc", spc_q, m_spc);
        cmp(tag, "ssr", ssr_q, m_ssr);
        cmp(tag, "sgr", sgr_q, m_sgr);
        cmp(tag, "evt", intevt_q, m_evt);
        cmp(tag, "gr15", gr15_nxt, gr15_in);
    endtask

    task automatic clr();
        sr_wr_en = 0; acc_req = 0; rst_entry = 0; mask_upd_en = 0; rte_req = 0;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        clr();
        pc_seq = pc_seq + 4;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        cmp("R1", "sr literal", sr_q, 32'h7000_00F0);
        cmp("R1", "pc literal", pc_q, 32'hA000_0000);
        rst_n = 1;
        pc_seq = 32'h0C00_1000; gr15_in = 32'h8800_0F00; vbr_in = 32'h8C00_0000;
        step("R11");
        step("R11");
        sr_wr_en = 1; sr_wr_data = 32'h0000_8030;       // FD=1, BL=0, mask=3
        step("R11");
        acc_req = 1; acc_lvl = 4'd2; evt_code = 14'h0111;
        step("R8");                                      // below mask
        acc_req = 1; acc_lvl = 4'd3; evt_code = 14'h0222;
        step("R8");                                      // equal to mask
        cmp("R8", "evt untouched", intevt_q, 32'h0);
        acc_req = 1; acc_lvl = 4'd5; evt_code = 14'h3BC0; gr15_in = 32'h8800_0EF0;
        step("R2");
        cmp("R3", "sr flags", sr_q, 32'h7000_8030);     // FD kept (R4), mask kept (R7)
        cmp("R6", "vector", pc_q, 32'h8C00_0600);
        cmp("R5", "evt", intevt_q, 32'h0000_3BC0);
        acc_req = 1; acc_lvl = 4'd15; evt_code = 14'h0333;
        step("R8");                                      // block bit set
        gr15_in = 32'h1234_5678; rte_req = 1;
        step("R9");
        cmp("R9", "sr restored", sr_q, 32'h0000_8030);
        cmp("R9", "gr15 not restored", gr15_nxt, 32'h1234_5678);
        acc_req = 1; acc_lvl = 4'd9; mask_upd_en = 1; evt_code = 14'h0400;
        step("R7");
        cmp("R7", "mask loaded", sr_q, 32'h7000_8090);
        step("R11");
        rte_req = 1;
        step("R9");
        acc_req = 1; acc_lvl = 4'd14; rte_req = 1;
        step("R10");
        cmp("R10", "no entry", intevt_q, 32'h0000_0400);
        rst_entry = 1; evt_code = 14'h0020; vbr_in = 32'hFFFF_FC00;
        step("R4");
        cmp("R4", "fd cleared", sr_q, 32'h7000_0030);
        cmp("R6", "wrap", pc_q, 32'h0000_0200);
        rst_entry = 1; mask_upd_en = 1; acc_lvl = 4'd1; rte_req = 1;
        step("R10");
        for (int i = 0; i < 400; i++) begin
            pc_seq      = $urandom;
            gr15_in     = $urandom;
            vbr_in      = $urandom;
            sr_wr_en    = ($urandom % 5) == 0;
            sr_wr_data  = $urandom & 32'h7000_80F0;
            acc_req     = ($urandom % 2) == 0;
            acc_lvl     = 4'($urandom);
            evt_code    = 14'($urandom);
            rst_entry   = ($urandom % 23) == 0;
            mask_upd_en = ($urandom % 2) == 0;
            rte_req     = ($urandom % 6) == 0;
            step("R8 R10 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule